// File: doc/BRIEF.md
# Four-Phase Reactive FSM Controller

This block wraps one extended finite state machine so that an outside scheduler decides when it runs. While it sits in idle it does nothing until the scheduler raises a grant. It then takes one atomic snapshot of the input event presence vector and its paired data word. It searches a small transition table with that snapshot and carries out at most one transition. Finally it puts out its output data and then its output events, and it reports completion to the scheduler. The four phases run in order and never overlap: idle, detect, transition, emit.

Each reaction is classified in one of three ways. A matching transition consumes the captured events, moves to the next state and writes outputs. A trivial transition consumes the captured events but changes neither state nor outputs. An empty reaction finds no match and consumes nothing. Right after reset the machine makes its initial reaction into the init state without any grant or event.

The example table has four states: INIT=0, RUN=1, HOLD=2 and LAST=3. There are four input events (bits 0..3) and three output events (bits 0..2). A rule matches when the current state equals the rule's source state and every event the rule needs is present in the snapshot. Each rule adds a constant to the captured data word.

Top module: `react_fsm_ctrl`

## Requirements
- R1: After reset is released, and with no grant, `sched_done` is high for exactly one cycle, in the second cycle after release. No event is emitted and nothing is consumed in that reaction. The machine is left in INIT.
- R2: Suppose a grant is sampled in idle at clock edge g. Then `ev_consume` carries that reaction's consume set in the cycle after edge g+2. `emit_ev` and `sched_done` are high in the cycle after edge g+3. `emit_ev` is never high without `sched_done`.
- R3: A snapshot with no event present is never a stimulus. The reaction consumes nothing, emits nothing, keeps the state and still raises `sched_done`.
- R4: On a match, `ev_consume` equals the whole captured vector. The state moves to the rule's target. `emit_ev` equals the rule's mask and `emit_data` = captured data + addend (mod 2^DATA_W). The table, given as source, needed events → target, emitted mask, addend, is: INIT,{0}→RUN,001,0; RUN,{1,2}→LAST,110,2; RUN,{1}→HOLD,010,1; RUN,{0}→RUN trivial; HOLD,{2}→INIT,100,3; HOLD,{3}→LAST,011,4; LAST,{3}→INIT,111,5; LAST,{0}→LAST trivial.
- R5: An empty reaction, where a nonzero snapshot matches no rule, consumes nothing, emits nothing, and leaves both the state and `emit_data` unchanged.
- R6: A trivial transition (RUN or LAST with event 0 as the only useful event) consumes the captured vector. It emits nothing and leaves the state and `emit_data` unchanged.
- R7: `emit_data` takes its new value one cycle before the matching `emit_ev` pulse and holds it while the pulse is high.
- R8: `sched_done` lasts one cycle. A grant seen while the machine is not in idle has no effect.
- R9: When several rules match, the one listed first in the R4 table wins. For example, RUN with events 1 and 2 both present goes to LAST.
- R10: Changes on `snap_ev` or `snap_data` after the capture edge do not affect the reaction in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sched_grant | input | 1 | Execute grant from the scheduler, honoured only in idle |
| sched_done | output | 1 | One-cycle pulse when a reaction ends |
| snap_ev | input | 4 | Input event presence vector |
| snap_data | input | DATA_W | Data word paired with the input events |
| ev_consume | output | 4 | One-cycle strobe clearing the consumed input events |
| emit_ev | output | 3 | One-cycle output event pulses |
| emit_data | output | DATA_W | Output data word, held between writes |

## Verification
Every one of the four states is combined with all sixteen snapshot patterns, each time after a fresh reset and a walk to that state. This sets apart matching, trivial, empty and zero-stimulus reactions, and shows whether priority picks the right rule. Because reactions are chained, an error in the state kept after a trivial or empty reaction shows up in the next reaction. A grant held across a whole reaction, and snapshot inputs flipped right after capture, show whether the phases stay locked and whether the snapshot is atomic.

// File: rtl/react_pkg.sv
package react_pkg;

    localparam int N_IN    = 4;
    localparam int N_OUT   = 3;
    localparam int ST_W    = 2;
    localparam int N_RULE  = 8;
    localparam int IDX_W   = $clog2(N_RULE);
    localparam int ADD_W   = 8;

    typedef enum logic [2:0] {
        PH_BOOT,
        PH_IDLE,
        PH_DETECT,
        PH_XFER,
        PH_EMIT
    } phase_e;

    localparam logic [ST_W-1:0] ST_INIT = 2'd0;
    localparam logic [ST_W-1:0] ST_RUN  = 2'd1;
    localparam logic [ST_W-1:0] ST_HOLD = 2'd2;
    localparam logic [ST_W-1:0] ST_LAST = 2'd3;

    typedef struct packed {
        logic [ST_W-1:0]  src;
        logic [N_IN-1:0]  need;
        logic [ST_W-1:0]  dst;
        logic [N_OUT-1:0] emit;
        logic [ADD_W-1:0] addend;
    } rule_t;

    // Lower index means higher priority.
    function automatic rule_t get_rule(input int idx);
        rule_t r;
        case (idx)
            0:       r = '{ST_INIT, 4'b0001, ST_RUN,  3'b001, 8'd0};
            1:       r = '{ST_RUN,  4'b0110, ST_LAST, 3'b110, 8'd2};
            2:       r = '{ST_RUN,  4'b0010, ST_HOLD, 3'b010, 8'd1};
            3:       r = '{ST_RUN,  4'b0001, ST_RUN,  3'b000, 8'd0};
            4:       r = '{ST_HOLD, 4'b0100, ST_INIT, 3'b100, 8'd3};
            5:       r = '{ST_HOLD, 4'b1000, ST_LAST, 3'b011, 8'd4};
            6:       r = '{ST_LAST, 4'b1000, ST_INIT, 3'b111, 8'd5};
            default: r = '{ST_LAST, 4'b0001, ST_LAST, 3'b000, 8'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/react_rule_match.sv
module react_rule_match
    import react_pkg::*;
(
    input  logic [ST_W-1:0]   cur_state,
    input  logic [N_IN-1:0]   ev_snap,
    output logic [N_RULE-1:0] rule_hit
);
    logic stimulus;
    assign stimulus = |ev_snap;

    for (genvar i = 0; i < N_RULE; i++) begin : g_rule
        localparam rule_t RULE = get_rule(i);
        assign rule_hit[i] = stimulus
                           && (cur_state == RULE.src)
                           && ((ev_snap & RULE.need) == RULE.need);
    end
endmodule

// File: rtl/react_prio_pick.sv
module react_prio_pick
    import react_pkg::*;
(
    input  logic [N_RULE-1:0] rule_hit,
    output logic              any_hit,
    output logic [IDX_W-1:0]  win_idx
);
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = N_RULE - 1; i >= 0; i--) begin
            if (rule_hit[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/react_fsm_ctrl.sv
module react_fsm_ctrl
    import react_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sched_grant,
    output logic              sched_done,
    input  logic [N_IN-1:0]   snap_ev,
    input  logic [DATA_W-1:0] snap_data,
    output logic [N_IN-1:0]   ev_consume,
    output logic [N_OUT-1:0]  emit_ev,
    output logic [DATA_W-1:0] emit_data
);
    phase_e              phase_q;
    logic [ST_W-1:0]     state_q;
    logic [N_IN-1:0]     snap_ev_q;
    logic [DATA_W-1:0]   snap_data_q;
    logic                hit_q;
    logic [IDX_W-1:0]    idx_q;

    logic [N_RULE-1:0]   rule_hit;
    logic                hit_c;
    logic [IDX_W-1:0]    idx_c;
    rule_t               sel;

    logic [N_IN-1:0]     consume_q;
    logic [N_OUT-1:0]    emit_q;
    logic [DATA_W-1:0]   data_q;
    logic                done_q;

    react_rule_match u_match (
        .cur_state (state_q),
        .ev_snap   (snap_ev_q),
        .rule_hit  (rule_hit)
    );

    react_prio_pick u_pick (
        .rule_hit (rule_hit),
        .any_hit  (hit_c),
        .win_idx  (idx_c)
    );

    always_comb sel = get_rule(int'(idx_q));

    // Phase sequencer and machine state
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_BOOT;
            state_q     <= ST_INIT;
            snap_ev_q   <= '0;
            snap_data_q <= '0;
            hit_q       <= 1'b0;
            idx_q       <= '0;
        end else begin
            unique case (phase_q)
                PH_BOOT: begin
                    state_q <= ST_INIT;
                    hit_q   <= 1'b0;
                    phase_q <= PH_EMIT;
                end
                PH_IDLE: begin
                    if (sched_grant) begin
                        snap_ev_q   <= snap_ev;
                        snap_data_q <= snap_data;
                        phase_q     <= PH_DETECT;
                    end
                end
                PH_DETECT: begin
                    hit_q   <= hit_c;
                    idx_q   <= idx_c;
                    phase_q <= PH_XFER;
                end
                PH_XFER: begin
                    if (hit_q) state_q <= sel.dst;
                    phase_q <= PH_EMIT;
                end
                PH_EMIT: begin
                    phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Output process: data is written one phase ahead of its events
    always_ff @(posedge clk) begin
        if (rst) begin
            consume_q <= '0;
            emit_q    <= '0;
            data_q    <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q    <= (phase_q == PH_EMIT);
            emit_q    <= (phase_q == PH_EMIT && hit_q) ? sel.emit : '0;
            consume_q <= (phase_q == PH_XFER && hit_q) ? snap_ev_q : '0;
            if (phase_q == PH_XFER && hit_q && (|sel.emit))
                data_q <= snap_data_q + DATA_W'(sel.addend);
        end
    end

    assign sched_done = done_q;
    assign ev_consume = consume_q;
    assign emit_ev    = emit_q;
    assign emit_data  = data_q;

endmodule

// File: rtl/react_fsm_chk.sv
module react_fsm_chk
    import react_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sched_grant,
    input logic              sched_done,
    input logic [N_IN-1:0]   ev_consume,
    input logic [N_OUT-1:0]  emit_ev,
    input logic [DATA_W-1:0] emit_data,
    input phase_e            phase,
    input logic [ST_W-1:0]   state
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sched_done |=> !sched_done);

    // R2
    emit_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        (|emit_ev) |-> sched_done);

    // R2
    consume_then_done_chk: assert property (@(posedge clk) disable iff (rst)
        (|ev_consume) |=> sched_done);

    // R7
    data_ahead_chk: assert property (@(posedge clk) disable iff (rst)
        (|emit_ev) |-> $stable(emit_data));

    // R5
    emit_needs_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (|emit_ev) |-> $past(|ev_consume));

    // R5
    state_moves_on_consume_chk: assert property (@(posedge clk) disable iff (rst)
        (state != $past(state)) |-> (|ev_consume));

    // R8
    busy_grant_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE && sched_grant) |=> (phase != PH_DETECT));

endmodule

bind react_fsm_ctrl react_fsm_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .sched_grant (sched_grant),
    .sched_done  (sched_done),
    .ev_consume  (ev_consume),
    .emit_ev     (emit_ev),
    .emit_data   (emit_data),
    .phase       (phase_q),
    .state       (state_q)
);

// File: tb/react_fsm_ctrl_tb_top.sv
module react_fsm_ctrl_tb_top;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          grant = 1'b0;
    logic          done;
    logic [3:0]    sev = '0;
    logic [DW-1:0] sdata = '0;
    logic [3:0]    cons;
    logic [2:0]    eev;
    logic [DW-1:0] edata;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // model state kept by the bench
    int            m_state;
    logic [DW-1:0] m_data;

    always #10 clk = ~clk;

    react_fsm_ctrl #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .sched_grant(grant), .sched_done(done),
        .snap_ev(sev), .snap_data(sdata), .ev_consume(cons),
        .emit_ev(eev), .emit_data(edata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected reaction from the R4 table, written as per-state decisions.
    task automatic model(input int st, input logic [3:0] ev,
                         output bit hit, output int dst,
                         output logic [2:0] em, output int add);
        hit = 0; dst = st; em = 3'b000; add = 0;
        case (st)
            0: if (ev[0]) begin hit = 1; dst = 1; em = 3'b001; add = 0; end
            1: if (ev[1] && ev[2]) begin hit = 1; dst = 3; em = 3'b110; add = 2; end
               else if (ev[1]) begin hit = 1; dst = 2; em = 3'b010; add = 1; end
               else if (ev[0]) begin hit = 1; end
            2: if (ev[2]) begin hit = 1; dst = 0; em = 3'b100; add = 3; end
               else if (ev[3]) begin hit = 1; dst = 3; em = 3'b011; add = 4; end
            default: if (ev[3]) begin hit = 1; dst = 0; em = 3'b111; add = 5; end
                     else if (ev[0]) begin hit = 1; end
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; grant = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R1 done early", done, 0);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b1, "R1 boot done", done, 1);
        chk(eev == 3'b000, "R1 boot emit", eev, 0);
        chk(cons == 4'b0000, "R1 boot consume", cons, 0);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R1 done width", done, 0);
        m_state = 0;
        m_data  = '0;
    endtask

    task automatic react(input logic [3:0] ev, input logic [DW-1:0] d);
        bit hit; int dst; logic [2:0] em; int add;
        string tag;
        logic [DW-1:0] exp_d;
        model(m_state, ev, hit, dst, em, add);
        if (ev == 4'b0) tag = "R3";
        else if (!hit) tag = "R5";
        else if (m_state == 1 && ev[1] && ev[2]) tag = "R9";
        else if (em == 3'b000) tag = "R6";
        else tag = "R4";
        exp_d = (hit && em != 3'b000) ? d + DW'(add) : m_data;
        @(negedge clk);
        sev = ev; sdata = d; grant = 1'b1;
        @(posedge clk);             // g: capture
        @(negedge clk);
        grant = 1'b0; sev = ~ev; sdata = ~d;   // R10: disturb after capture
        @(posedge clk); @(posedge clk); @(negedge clk);   // after g+2
        chk(cons == (hit ? ev : 4'b0), {tag, " R2 R10 consume"}, cons, hit ? ev : 0);
        chk(eev == 3'b000, {tag, " R2 emit early"}, eev, 0);
        chk(edata == exp_d, {tag, " R7 data ahead"}, edata, exp_d);
        chk(done == 1'b0, {tag, " R2 done early"}, done, 0);
        @(posedge clk); @(negedge clk);                   // after g+3
        chk(eev == em, {tag, " R2 emit"}, eev, em);
        chk(done == 1'b1, {tag, " R2 done"}, done, 1);
        chk(cons == 4'b0, {tag, " R2 consume width"}, cons, 0);
        chk(edata == exp_d, {tag, " R7 data hold"}, edata, exp_d);
        m_state = dst;
        m_data  = exp_d;
        sev = '0;
    endtask

    initial begin
        do_reset();
        // walk to each state and try every snapshot there
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 16; p++) begin
                do_reset();
                if (s >= 1) react(4'b0001, 8'h10);
                if (s == 2) react(4'b0010, 8'h20);
                if (s == 3) react(4'b0110, 8'h30);
                react(4'(p), 8'(8'hF0 + 16 * s + p));
                // follow-up reveals the kept state (R5, R6)
                react(4'b1000, 8'hFE);
                react(4'b0001, 8'h05);
            end
        end
        // R8: grant held across a reaction is honoured once
        do_reset();
        begin
            int n_done = 0;
            @(negedge clk); sev = 4'b0001; sdata = 8'h42; grant = 1'b1;
            for (int c = 0; c < 3; c++) begin
                @(posedge clk); @(negedge clk);
                if (done) n_done++;
            end
            grant = 1'b0; sev = '0;
            for (int c = 0; c < 4; c++) begin
                @(posedge clk); @(negedge clk);
                if (done) n_done++;
            end
            chk(n_done == 1, "R8 single done", n_done, 1);
            chk(edata == 8'h42, "R8 data", edata, 8'h42);
            m_state = 1; m_data = 8'h42;
            react(4'b0010, 8'h07);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule